// File: doc/BRIEF.md
# External Interrupt Trigger Conditioner

This block turns up to six asynchronous external interrupt pins into clean per-pin request lines for an interrupt controller. Each pin is first brought into the clock domain through a synchroniser whose depth is a parameter. A per-pin trigger code then chooses how the pin raises its request: on a rising edge, on a falling edge, on either edge, while the pin is high, or while it is low. A code can also shut the pin off.

Software programs the block through a 32-bit word-addressed register port. Three registers are writable: trigger codes, enables and pending flags. Edge events are latched in the pending flag until software writes a zero to that bit. In level modes the pending flag simply shows whether the pin is at its active level. A request output is raised only while the pin is both pending and enabled. Driver code normally programs code 6 (active-low level) when it brings a pin into service. The register file itself resets with every pin off.

Top module: `ext_irq_trigger`

## Requirements
- R1: After reset the trigger-code, enable and pending words all read 0, and every request output is 0.
- R2: Word address 0 holds the trigger codes. Pin i uses the 4-bit field starting at bit 4*i. Only the low 3 bits of each field are stored, and bit 3 of every field reads 0. Word address 3 always reads 0.
- R3: With code 1, a rising edge on the synchronised pin sets its pending flag, and a falling edge leaves the flag clear.
- R4: With code 2, a falling edge sets the pending flag, and a rising edge leaves the flag clear.
- R5: With code 3, both a rising edge and a falling edge set the pending flag.
- R6: With code 5, the pending flag (bit i of word address 2) equals the synchronised pin level. Writing 0 to that bit has no effect.
- R7: With code 6, the pending flag equals the inverse of the synchronised pin level.
- R8: Codes 0, 4 and 7 never set the pending flag and never raise a request, whatever the pin does.
- R9: In edge modes the pending flag is held until a write to word address 2 carries 0 in that bit. Writing 1 leaves it unchanged. An edge detected in the same cycle as the clearing write wins, and the flag stays set.
- R10: Word address 1 holds one enable bit per pin at bit i. Request output i equals pending flag i AND enable bit i. A disabled pin still records its pending flag.
- R11: A pin change that is stable before a clock edge reaches a request output, in edge mode, after SYNC_STAGES+1 rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | NUM_PINS | Asynchronous external interrupt pins |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address: 0 codes, 1 enable, 2 pending |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| req_o | output | NUM_PINS | Per-pin interrupt requests |

## Verification
The critical overlap is a software write that clears a pending flag landing in the same cycle as a new edge detection on that pin. The bench changes a pin on a falling clock edge and waits exactly two rising edges. It then presents a write of zero to the pending word for one cycle, so the write coincides with the cycle in which the edge is detected. The flag must read back set afterwards, and a second, non-overlapping write must then clear it.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned FIELD_W = 4;

  localparam logic [CODE_W-1:0] TRIG_OFF  = 3'd0;
  localparam logic [CODE_W-1:0] TRIG_RISE = 3'd1;
  localparam logic [CODE_W-1:0] TRIG_FALL = 3'd2;
  localparam logic [CODE_W-1:0] TRIG_BOTH = 3'd3;
  localparam logic [CODE_W-1:0] TRIG_HIGH = 3'd5;
  localparam logic [CODE_W-1:0] TRIG_LOW  = 3'd6;

  localparam logic [ADDR_W-1:0] ADDR_CODE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PEND = 2'd2;

  function automatic logic is_edge_code(input logic [CODE_W-1:0] c);
    return (c == TRIG_RISE) || (c == TRIG_FALL) || (c == TRIG_BOTH);
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/trig_cell.sv
module trig_cell
  import ext_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvl_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              clr_i,
  output logic              hit_o,
  output logic              latch_o,
  output logic              pend_o
);
  logic prev_q, latch_q;
  logic rise, fall, edge_mode, lvl_act;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;
  assign edge_mode = is_edge_code(code_i);

  always_comb begin
    unique case (code_i)
      TRIG_RISE: hit_o = rise;
      TRIG_FALL: hit_o = fall;
      TRIG_BOTH: hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
    unique case (code_i)
      TRIG_HIGH: lvl_act = lvl_i;
      TRIG_LOW:  lvl_act = ~lvl_i;
      default:   lvl_act = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      if (!edge_mode)  latch_q <= 1'b0;
      else if (hit_o)  latch_q <= 1'b1;  // new edge beats a same-cycle clear
      else if (clr_i)  latch_q <= 1'b0;
    end
  end

  assign latch_o = latch_q;
  assign pend_o  = edge_mode ? latch_q : lvl_act;
endmodule

// File: rtl/ext_irq_trigger.sv
module ext_irq_trigger
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic [NUM_PINS-1:0] req_o
);
  localparam int unsigned CFG_W = NUM_PINS * CODE_W;

  logic [NUM_PINS-1:0] lvl_s, hit_v, latch_v, pend_v, clr_v, en_q;
  logic [CFG_W-1:0]    cfg_flat;
  logic                wr_code, wr_en, wr_pend;

  assign wr_code = reg_we_i && (reg_addr_i == ADDR_CODE);
  assign wr_en   = reg_we_i && (reg_addr_i == ADDR_EN);
  assign wr_pend = reg_we_i && (reg_addr_i == ADDR_PEND);

  pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (lvl_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_flat <= '0;
      en_q     <= '0;
    end else begin
      if (wr_code)
        for (int i = 0; i < NUM_PINS; i++)
          cfg_flat[i*CODE_W +: CODE_W] <= reg_wdata_i[i*FIELD_W +: CODE_W];
      if (wr_en) en_q <= reg_wdata_i[NUM_PINS-1:0];
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign clr_v[g] = wr_pend & ~reg_wdata_i[g];
    trig_cell i_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (lvl_s[g]),
      .code_i (cfg_flat[g*CODE_W +: CODE_W]),
      .clr_i  (clr_v[g]),
      .hit_o  (hit_v[g]),
      .latch_o(latch_v[g]),
      .pend_o (pend_v[g])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CODE:
        for (int i = 0; i < NUM_PINS; i++)
          reg_rdata_o[i*FIELD_W +: CODE_W] = cfg_flat[i*CODE_W +: CODE_W];
      ADDR_EN:   reg_rdata_o[NUM_PINS-1:0] = en_q;
      ADDR_PEND: reg_rdata_o[NUM_PINS-1:0] = pend_v;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign req_o = pend_v & en_q;
endmodule

// File: rtl/ext_irq_trigger_chk.sv
module ext_irq_trigger_chk
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 6
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         reg_we_i,
  input logic [ADDR_W-1:0]            reg_addr_i,
  input logic [DATA_W-1:0]            reg_wdata_i,
  input logic [NUM_PINS*CODE_W-1:0]   cfg_flat,
  input logic [NUM_PINS-1:0]          en_q,
  input logic [NUM_PINS-1:0]          hit_v,
  input logic [NUM_PINS-1:0]          latch_v,
  input logic [NUM_PINS-1:0]          req_o
);
  logic [NUM_PINS*CODE_W-1:0] cfg_exp;
  logic wr_code, wr_en, wr_pend;

  always_comb
    for (int i = 0; i < NUM_PINS; i++)
      cfg_exp[i*CODE_W +: CODE_W] = reg_wdata_i[i*FIELD_W +: CODE_W];

  assign wr_code = reg_we_i && (reg_addr_i == ADDR_CODE);
  assign wr_en   = reg_we_i && (reg_addr_i == ADDR_EN);
  assign wr_pend = reg_we_i && (reg_addr_i == ADDR_PEND);

  assert_code_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_code |=> cfg_flat == $past(cfg_exp));

  assert_en_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> en_q == $past(reg_wdata_i[NUM_PINS-1:0]));

  assert_req_blocked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en) |-> (req_o & ~en_q) == '0);

  assert_edge_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|hit_v) && !wr_code) |=> (latch_v & $past(hit_v)) == $past(hit_v));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pend |=> (latch_v & ~$past(reg_wdata_i[NUM_PINS-1:0]) & ~$past(hit_v)) == '0);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_pend || wr_code) |=> (latch_v & $past(latch_v)) == $past(latch_v));
endmodule

bind ext_irq_trigger ext_irq_trigger_chk #(.NUM_PINS(NUM_PINS)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .cfg_flat   (cfg_flat),
  .en_q       (en_q),
  .hit_v      (hit_v),
  .latch_v    (latch_v),
  .req_o      (req_o)
);

// File: tb/test_ext_irq_trigger.sv
module test_ext_irq_trigger;
  localparam int NP = 6;
  localparam int SS = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          we = 1'b0;
  logic [1:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] req;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ext_irq_trigger #(.NUM_PINS(NP), .SYNC_STAGES(SS)) i_ext_irq_trigger (
    .clk_i(clk), .rst_ni(rst_ni), .pins_i(pins), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .req_o(req)
  );

  // pin0 rise, pin1 fall, pin2 both, pin3 high, pin4 low, pin5 off
  localparam logic [31:0] CFG_BASE = 32'h0006_5321;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic set_pin(input int idx, input logic v);
    @(negedge clk); pins[idx] = v;
    repeat (SS + 2) @(posedge clk);
  endtask

  task automatic pend_bit(input string tag, input int idx, input logic exp);
    logic [31:0] d;
    rd(2'd2, d);
    check(tag, {31'b0, d[idx]}, {31'b0, exp});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 3; a++) begin
      rd(a[1:0], d);
      check("R1 reset word", d, 32'h0);
    end
    check("R1 reset req", {26'b0, req}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d);
    check("R2 code field mask", d, 32'h0077_7777);
    wr(2'd0, CFG_BASE);
    rd(2'd0, d);
    check("R2 code readback", d, CFG_BASE);
    rd(2'd3, d);
    check("R2 unused word", d, 32'h0);
    wr(2'd1, 32'h3F);
    rd(2'd1, d);
    check("R10 enable readback", d, 32'h3F);
    wr(2'd2, 32'h0);
  endtask

  task automatic t_rise;
    set_pin(0, 1'b1);
    pend_bit("R3 rise sets", 0, 1'b1);
    check("R3 rise req", {31'b0, req[0]}, 32'h1);
    wr(2'd2, ~32'h1);
    set_pin(0, 1'b0);
    pend_bit("R3 fall ignored", 0, 1'b0);
  endtask

  task automatic t_fall;
    set_pin(1, 1'b1);
    pend_bit("R4 rise ignored", 1, 1'b0);
    set_pin(1, 1'b0);
    pend_bit("R4 fall sets", 1, 1'b1);
    wr(2'd2, ~32'h2);
    pend_bit("R4 cleared", 1, 1'b0);
  endtask

  task automatic t_both;
    set_pin(2, 1'b1);
    pend_bit("R5 rise sets", 2, 1'b1);
    wr(2'd2, ~32'h4);
    pend_bit("R5 cleared", 2, 1'b0);
    set_pin(2, 1'b0);
    pend_bit("R5 fall sets", 2, 1'b1);
    wr(2'd2, ~32'h4);
  endtask

  task automatic t_high;
    set_pin(3, 1'b1);
    pend_bit("R6 high pending", 3, 1'b1);
    wr(2'd2, 32'h0);
    pend_bit("R6 write0 ignored", 3, 1'b1);
    check("R6 high req", {31'b0, req[3]}, 32'h1);
    set_pin(3, 1'b0);
    pend_bit("R6 low drops", 3, 1'b0);
  endtask

  task automatic t_low;
    pend_bit("R7 low pending", 4, 1'b1);
    set_pin(4, 1'b1);
    pend_bit("R7 high drops", 4, 1'b0);
    check("R7 req off", {31'b0, req[4]}, 32'h0);
    set_pin(4, 1'b0);
    check("R7 req on", {31'b0, req[4]}, 32'h1);
  endtask

  task automatic t_off;
    logic [31:0] c;
    for (int k = 0; k < 3; k++) begin
      c = (k == 0) ? 32'h0 : (k == 1) ? 32'h4 : 32'h7;
      wr(2'd0, (CFG_BASE & 32'hFF0F_FFFF) | (c << 20));
      set_pin(5, 1'b1);
      pend_bit("R8 off on rise", 5, 1'b0);
      set_pin(5, 1'b0);
      pend_bit("R8 off on fall", 5, 1'b0);
      check("R8 off req", {31'b0, req[5]}, 32'h0);
    end
    wr(2'd0, CFG_BASE);
  endtask

  task automatic t_clear;
    set_pin(0, 1'b1);
    wr(2'd2, 32'hFFFF_FFFF);
    pend_bit("R9 write1 keeps", 0, 1'b1);
    wr(2'd2, ~32'h1);
    set_pin(0, 1'b0);
    pend_bit("R9 precondition", 0, 1'b0);
    // edge detected in the same cycle as the clearing write
    @(negedge clk); pins[0] = 1'b1;
    repeat (SS) @(posedge clk);
    @(negedge clk); we = 1'b1; addr = 2'd2; wdata = 32'h0;
    @(negedge clk); we = 1'b0;
    pend_bit("R9 edge beats clear", 0, 1'b1);
    wr(2'd2, ~32'h1);
    pend_bit("R9 later clear", 0, 1'b0);
    set_pin(0, 1'b0);
  endtask

  task automatic t_latency;
    @(negedge clk); pins[2] = 1'b1;
    repeat (SS) @(posedge clk);
    #1 check("R11 not yet", {31'b0, req[2]}, 32'h0);
    @(posedge clk);
    #1 check("R11 request", {31'b0, req[2]}, 32'h1);
    wr(2'd2, ~32'h4);
  endtask

  task automatic t_enable;
    wr(2'd1, 32'h0);
    set_pin(2, 1'b0);
    pend_bit("R10 pending while off", 2, 1'b1);
    check("R10 req blocked", {26'b0, req}, 32'h0);
    wr(2'd1, 32'h4);
    check("R10 req on enable", {26'b0, req}, 32'h4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    t_reset();
    t_regs();
    t_rise();
    t_fall();
    t_both();
    t_high();
    t_low();
    t_off();
    t_clear();
    t_latency();
    t_enable();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule